// File: doc/BRIEF.md
# Internal Cycle Visibility Gate

This block stands between the bus of a small microcontroller core and the external bus pins. On every clock it chooses what the address pins, the data pins and the active-low strobes show. External accesses always reach the pins. Internal accesses reach the pins only when a configuration bit permits it. When an internal access is hidden, the pins do not float. They keep replaying the address and data of the most recent external access, and every strobe stays high.

A two-bit configuration register holds two enables. The first makes internal cycles visible. The second lets the opcode-fetch strobe be driven. A mode input picks between single-chip and emulation behaviour. In emulation, both enables read as set and cannot be cleared. Internal address and data are then always shown, and a separate gate input decides only whether the strobes fire during internal cycles.

The address decoder supplies per-cycle qualifiers: valid, external, write, opcode fetch, last clock of the access, and one-hot chip selects. The block does not decode addresses and does not model the pads.

Top module: `vis_bus_gate`

## Requirements
- R1: After reset in single-chip mode, `cfgRdData` reads 0x00. After reset in emulation mode, it reads 0x03. Bit 0 is the internal-visibility enable and bit 1 is the fetch-strobe enable. All other read bits are 0.
- R2: In single-chip mode with bit 0 clear, any internal access (valid, not external) holds `pinRdN`, `pinWrN`, every `pinCsN` bit and `pinLirN` high.
- R3: While no access is shown (a hidden internal access, or an idle clock), `pinAddr` and `pinData` carry the shadow address and shadow data, and `pinDataOe` is 1.
- R4: The shadow address loads `cycAddr` on every clock of an external access. The shadow data loads `cycWrData` on every clock of an external write. It loads `extRdData` only on the last clock (`cycLast`=1) of an external read.
- R5: With bit 0 set, an internal access drives `cycAddr` on the pins. The data pins carry `cycWrData` for a write or `intRdData` for a read. The strobes behave as for an external cycle: `pinRdN` low on reads, `pinWrN` low on writes, and `pinCsN[i]` low where `decCs[i]` is 1.
- R6: An external access always drives its address and strobes, whatever the configuration. During an external read, `pinDataOe` is 0.
- R7: `pinLirOe` equals the fetch-strobe enable (bit 1). `pinLirN` goes low only on the last clock of an opcode-fetch access whose strobes are enabled, and only while `pinLirOe` is 1.
- R8: In emulation mode a configuration write leaves both bits set.
- R9: In emulation mode, internal accesses always show their address and data. `extGateEn`=0 keeps `pinRdN`, `pinWrN`, `pinCsN` and `pinLirN` high on those accesses. `extGateEn`=1 lets them fire.
- R10: In single-chip mode a configuration write loads bits 1:0 from `cfgWrData` and ignores bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| emuMode | input | 1 | 1 selects emulation behaviour, 0 selects single-chip |
| extGateEn | input | 1 | Emulation only: lets strobes fire on internal cycles |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read-back |
| cycValid | input | 1 | A bus access is in progress this clock |
| cycExternal | input | 1 | Decoder flags the access as external |
| cycWrite | input | 1 | Access is a write |
| cycFetch | input | 1 | Access is an opcode fetch |
| cycLast | input | 1 | Final clock of the access |
| cycAddr | input | 13 | Core address |
| cycWrData | input | 8 | Core write data |
| intRdData | input | 8 | Internal read data from the core bus |
| extRdData | input | 8 | Data sampled from the external data pins |
| decCs | input | 4 | One-hot chip selects from the decoder, active high |
| pinAddr | output | 13 | External address pins |
| pinData | output | 8 | External data pins, output value |
| pinDataOe | output | 1 | Data pin output enable |
| pinRdN | output | 1 | Read strobe, active low |
| pinWrN | output | 1 | Write strobe, active low |
| pinCsN | output | 4 | Chip selects, active low |
| pinLirN | output | 1 | Opcode-fetch strobe, active low |
| pinLirOe | output | 1 | Opcode-fetch strobe output enable |

## Verification
The assertions assume that `decCs` is one-hot or zero, that `emuMode` changes only while reset is held, and that no access is both a write and an opcode fetch. The stimulus meets all three assumptions:
- It drives exactly one chip select per access.
- It changes the mode only inside a reset pulse.
- It marks only reads as fetches.

It also issues each configuration write on a clock with no bus access, so register updates and shadow updates never share an edge.

// File: rtl/vis_gate_pkg.sv
package vis_gate_pkg;

  // Strobes from control to datapath for the current clock.
  typedef struct packed {
    logic showCycle;   // present the live access on address/data pins
    logic selWrData;   // live data comes from the write path
    logic selIntRd;    // live data comes from internal read data
    logic driveData;   // data pins are outputs this clock
    logic captAddr;    // load shadow address
    logic captWrData;  // load shadow data from write path
    logic captRdData;  // load shadow data from external read
  } gateCtl_t;

  localparam int CFG_VIS_BIT = 0;
  localparam int CFG_LIR_BIT = 1;

endpackage

// File: rtl/vis_gate_ctrl.sv
module vis_gate_ctrl
  import vis_gate_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int CS_NUM = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              emuMode,
  input  logic              extGateEn,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              cycValid,
  input  logic              cycExternal,
  input  logic              cycWrite,
  input  logic              cycFetch,
  input  logic              cycLast,
  input  logic [CS_NUM-1:0] decCs,
  output gateCtl_t          ctl,
  output logic              pinRdN,
  output logic              pinWrN,
  output logic [CS_NUM-1:0] pinCsN,
  output logic              pinLirN,
  output logic              pinLirOe
);

  localparam int HI_W = CFG_W - 2;

  logic visBit;
  logic lirBit;
  logic accExt;
  logic accInt;
  logic visEff;
  logic strobeEn;
  logic [HI_W-1:0] unusedCfgHi;

  assign unusedCfgHi = cfgWrData[CFG_W-1:2];

  // Configuration register; emulation forces both enables set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      visBit <= emuMode;
      lirBit <= emuMode;
    end else if (cfgWrEn) begin
      visBit <= emuMode | cfgWrData[CFG_VIS_BIT];
      lirBit <= emuMode | cfgWrData[CFG_LIR_BIT];
    end
  end

  always_comb begin
    cfgRdData              = '0;
    cfgRdData[CFG_VIS_BIT] = visBit;
    cfgRdData[CFG_LIR_BIT] = lirBit;
  end

  assign accExt   = cycValid & cycExternal;
  assign accInt   = cycValid & ~cycExternal;
  assign visEff   = emuMode | visBit;
  assign strobeEn = accExt | (accInt & (emuMode ? extGateEn : visBit));

  always_comb begin
    ctl.showCycle  = accExt | (accInt & visEff);
    ctl.selWrData  = cycWrite;
    ctl.selIntRd   = accInt & ~cycWrite;
    ctl.driveData  = ~(accExt & ~cycWrite);
    ctl.captAddr   = accExt;
    ctl.captWrData = accExt & cycWrite;
    ctl.captRdData = accExt & ~cycWrite & cycLast;
  end

  assign pinRdN = ~(strobeEn & ~cycWrite);
  assign pinWrN = ~(strobeEn & cycWrite);

  genvar gi;
  generate
    for (gi = 0; gi < CS_NUM; gi++) begin : g_cs
      assign pinCsN[gi] = ~(strobeEn & decCs[gi]);
    end
  endgenerate

  assign pinLirOe = emuMode | lirBit;
  assign pinLirN  = ~(pinLirOe & strobeEn & cycFetch & cycLast);

  // R2: hidden internal access keeps every strobe high
  assert_hidden_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycExternal && !emuMode && !cfgRdData[CFG_VIS_BIT])
      |-> (pinRdN && pinWrN && (&pinCsN) && pinLirN));

  // R8: emulation write leaves both enables set
  assert_emu_cfg_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && emuMode) |=> (cfgRdData[1:0] == 2'b11));

  // R7: fetch strobe stays high while its output is not enabled
  assert_lir_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pinLirOe |-> pinLirN);

  // R5: read and write strobes never both low; at most one chip select low
  assert_rdwr_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!pinRdN && !pinWrN) && $onehot0(~pinCsN));

endmodule

// File: rtl/vis_gate_dpath.sv
module vis_gate_dpath
  import vis_gate_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateCtl_t          ctl,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W-1:0] cycWrData,
  input  logic [DATA_W-1:0] intRdData,
  input  logic [DATA_W-1:0] extRdData,
  output logic [ADDR_W-1:0] pinAddr,
  output logic [DATA_W-1:0] pinData,
  output logic              pinDataOe
);

  logic [ADDR_W-1:0] shadowAddr;
  logic [DATA_W-1:0] shadowData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowAddr <= '0;
      shadowData <= '0;
    end else begin
      if (ctl.captAddr)        shadowAddr <= cycAddr;
      if (ctl.captWrData)      shadowData <= cycWrData;
      else if (ctl.captRdData) shadowData <= extRdData;
    end
  end

  always_comb begin
    pinAddr = ctl.showCycle ? cycAddr : shadowAddr;
    if (!ctl.showCycle)     pinData = shadowData;
    else if (ctl.selWrData) pinData = cycWrData;
    else if (ctl.selIntRd)  pinData = intRdData;
    else                    pinData = shadowData;
  end

  assign pinDataOe = ctl.driveData;

  // R4: shadow address follows every external clock
  assert_shadow_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captAddr |=> (shadowAddr == $past(cycAddr)));

  // R4: shadow data holds unless a capture strobe is raised
  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.captWrData && !ctl.captRdData) |=> $stable(shadowData));

  // R6: external read never drives the data pins
  assert_ext_read_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captAddr && !ctl.captWrData) |-> !pinDataOe);

endmodule

// File: rtl/vis_bus_gate.sv
module vis_bus_gate
  import vis_gate_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int CFG_W  = 8,
  parameter int CS_NUM = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              emuMode,
  input  logic              extGateEn,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              cycValid,
  input  logic              cycExternal,
  input  logic              cycWrite,
  input  logic              cycFetch,
  input  logic              cycLast,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W-1:0] cycWrData,
  input  logic [DATA_W-1:0] intRdData,
  input  logic [DATA_W-1:0] extRdData,
  input  logic [CS_NUM-1:0] decCs,
  output logic [ADDR_W-1:0] pinAddr,
  output logic [DATA_W-1:0] pinData,
  output logic              pinDataOe,
  output logic              pinRdN,
  output logic              pinWrN,
  output logic [CS_NUM-1:0] pinCsN,
  output logic              pinLirN,
  output logic              pinLirOe
);

  gateCtl_t ctl;

  vis_gate_ctrl #(.CFG_W(CFG_W), .CS_NUM(CS_NUM)) u_ctrl (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .extGateEn(extGateEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .cycValid(cycValid), .cycExternal(cycExternal), .cycWrite(cycWrite),
    .cycFetch(cycFetch), .cycLast(cycLast), .decCs(decCs), .ctl(ctl),
    .pinRdN(pinRdN), .pinWrN(pinWrN), .pinCsN(pinCsN),
    .pinLirN(pinLirN), .pinLirOe(pinLirOe)
  );

  vis_gate_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycAddr(cycAddr),
    .cycWrData(cycWrData), .intRdData(intRdData), .extRdData(extRdData),
    .pinAddr(pinAddr), .pinData(pinData), .pinDataOe(pinDataOe)
  );

  // R9: in emulation an internal access always shows its address
  assert_emu_addr_shown_R9: assert property (@(posedge clk) disable iff (!rstN)
    (emuMode && cycValid && !cycExternal) |-> (pinAddr == cycAddr));

endmodule

// File: tb/vis_bus_gate_test.sv
module vis_bus_gate_test;

  logic        clk = 0;
  logic        rstN = 0;
  logic        emuMode = 0, extGateEn = 0, cfgWrEn = 0;
  logic [7:0]  cfgWrData = 0, cfgRdData;
  logic        cycValid = 0, cycExternal = 0, cycWrite = 0, cycFetch = 0, cycLast = 0;
  logic [12:0] cycAddr = 0, pinAddr;
  logic [7:0]  cycWrData = 0, intRdData = 0, extRdData = 0, pinData;
  logic [3:0]  decCs = 0, pinCsN;
  logic        pinDataOe, pinRdN, pinWrN, pinLirN, pinLirOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vis_bus_gate uut (.*);

  typedef struct packed {
    logic [1:0]  cfg;
    logic        valid, ext, wr, fetch, last;
    logic [12:0] addr;
    logic [7:0]  wd, ird, erd;
    logic [3:0]  cs;
    logic [12:0] eAddr;
    logic [7:0]  eData;
    logic        eOe, eRd, eWr;
    logic [3:0]  eCs;
    logic        eLir, eLirOe;
  } vec_t;

  // Single-chip walk; shadow state carries from one row to the next.
  localparam vec_t VECS [12] = '{
    '{2'b00,1,1,0,0,1,13'h0123,8'h00,8'h00,8'h5A,4'b0001, 13'h0123,8'h00,0,0,1,4'b1110,1,0},
    '{2'b00,1,0,0,0,1,13'h0040,8'h00,8'h77,8'h00,4'b0010, 13'h0123,8'h5A,1,1,1,4'b1111,1,0},
    '{2'b00,1,0,1,0,1,13'h0041,8'h33,8'h00,8'h00,4'b0010, 13'h0123,8'h5A,1,1,1,4'b1111,1,0},
    '{2'b01,1,0,0,0,1,13'h0042,8'h00,8'h99,8'h00,4'b0100, 13'h0042,8'h99,1,0,1,4'b1011,1,0},
    '{2'b01,1,1,1,0,1,13'h1ABC,8'hC3,8'h00,8'h00,4'b1000, 13'h1ABC,8'hC3,1,1,0,4'b0111,1,0},
    '{2'b10,1,0,0,1,1,13'h0050,8'h00,8'h11,8'h00,4'b0001, 13'h1ABC,8'hC3,1,1,1,4'b1111,1,1},
    '{2'b11,1,0,0,1,1,13'h0051,8'h00,8'h22,8'h00,4'b0001, 13'h0051,8'h22,1,0,1,4'b1110,0,1},
    '{2'b10,1,1,0,1,1,13'h0200,8'h00,8'h00,8'hE7,4'b0010, 13'h0200,8'hC3,0,0,1,4'b1101,0,1},
    '{2'b00,1,0,0,0,1,13'h0010,8'h00,8'h66,8'h00,4'b0001, 13'h0200,8'hE7,1,1,1,4'b1111,1,0},
    '{2'b11,1,1,0,1,0,13'h0300,8'h00,8'h00,8'h44,4'b0001, 13'h0300,8'hE7,0,0,1,4'b1110,1,1},
    '{2'b00,1,0,0,0,1,13'h0011,8'h00,8'h55,8'h00,4'b0001, 13'h0300,8'hE7,1,1,1,4'b1111,1,0},
    '{2'b11,0,0,0,0,0,13'h0777,8'h00,8'h00,8'h00,4'b0000, 13'h0300,8'hE7,1,1,1,4'b1111,1,1}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idleBus();
    cycValid = 0; cycExternal = 0; cycWrite = 0; cycFetch = 0; cycLast = 0; decCs = 0;
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk);
    idleBus();
    cfgWrEn = 1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic doReset(input logic emu);
    @(negedge clk);
    rstN = 0; emuMode = emu;
    idleBus();
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset(0);
    #1;
    // R1: single-chip reset state
    check("R1 cfg after reset", cfgRdData, 8'h00);
    check("R1 R7 lir oe after reset", pinLirOe, 0);
    check("R3 addr after reset", pinAddr, 0);
    check("R3 strobes idle", {pinRdN, pinWrN, pinCsN, pinLirN}, 7'h7F);
    // R10: upper bits ignored
    cfgWrite(8'hFC); #1;
    check("R10 upper bits ignored", cfgRdData, 8'h00);
    cfgWrite(8'h03); #1;
    check("R10 both bits loaded", cfgRdData, 8'h03);

    for (int i = 0; i < 12; i++) begin
      cfgWrite({6'b0, VECS[i].cfg});
      cycValid = VECS[i].valid; cycExternal = VECS[i].ext; cycWrite = VECS[i].wr;
      cycFetch = VECS[i].fetch; cycLast = VECS[i].last; cycAddr = VECS[i].addr;
      cycWrData = VECS[i].wd; intRdData = VECS[i].ird; extRdData = VECS[i].erd;
      decCs = VECS[i].cs;
      #3;
      check($sformatf("vec %0d pinAddr (R3,R4,R5,R6)", i), pinAddr, VECS[i].eAddr);
      check($sformatf("vec %0d pinData (R3,R4,R5)", i), pinData, VECS[i].eData);
      check($sformatf("vec %0d pinDataOe (R3,R6)", i), pinDataOe, VECS[i].eOe);
      check($sformatf("vec %0d rd/wr (R2,R5,R6)", i), {pinRdN, pinWrN}, {VECS[i].eRd, VECS[i].eWr});
      check($sformatf("vec %0d pinCsN (R2,R5)", i), pinCsN, VECS[i].eCs);
      check($sformatf("vec %0d lir (R7)", i), {pinLirN, pinLirOe}, {VECS[i].eLir, VECS[i].eLirOe});
      @(posedge clk);
    end

    // Emulation behaviour
    doReset(1);
    #1;
    check("R1 R8 emu cfg after reset", cfgRdData, 8'h03);
    cfgWrite(8'h00); #1;
    check("R8 emu write ignored", cfgRdData, 8'h03);
    @(negedge clk);
    extGateEn = 0;
    cycValid = 1; cycExternal = 0; cycWrite = 0; cycFetch = 1; cycLast = 1;
    cycAddr = 13'h0444; intRdData = 8'h5D; decCs = 4'b0001;
    #3;
    check("R9 emu addr shown gate off", pinAddr, 13'h0444);
    check("R9 emu data shown gate off", pinData, 8'h5D);
    check("R9 emu strobes gated off", {pinRdN, pinWrN, pinCsN, pinLirN}, 7'h7F);
    check("R9 R7 emu lir oe", pinLirOe, 1);
    @(negedge clk);
    extGateEn = 1;
    #3;
    check("R9 emu strobes with gate", {pinRdN, pinWrN, pinCsN, pinLirN}, {1'b0, 1'b1, 4'b1110, 1'b0});
    @(negedge clk);
    idleBus();
    #1;
    check("R3 emu idle shows shadow", pinAddr, 13'h0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule